// File: doc/BRIEF.md
# Coprocessor Response Primitive Sequencer

This block is the response register of a coprocessor interface. A host processor polls it to learn what the coprocessor needs next. The register holds one 16-bit response word. Bit 15 is the come-again flag, bit 14 is the interrupts-allowed flag, and bits 3:0 carry a primitive code: 0 is null, 1 is take-mid-instruction-exception, 2 is evaluate-effective-address-and-transfer, and 3 is done. The word follows the state of the instruction in progress, a busy-unit indication and a sticky exception flag.

A host read returns the word. Reading a transfer or done primitive consumes it, and the sequencer moves on to the next primitive. Reading a null primitive leaves it in place. An exception raised by either execution unit is latched and takes precedence over every primitive except the start-of-instruction busy wait. A write to the exception-acknowledge register does not clear the exception. Only a context-save strobe clears it. If a handler omits the save, the next coprocessor instruction reports the same exception again.

Top module: `rsp_seq_top`

## Requirements
- R1: Synchronous active-high reset makes the response word 0x0000 and discards any latched exception, so an instruction started after reset with the unit free shows 0xC000 and not 0x0001.
- R2: An instruction start while unit_busy is high gives 0xC000 (null with come-again and interrupts-allowed set). The word stays 0xC000 as long as unit_busy is high, even with an exception pending. Once unit_busy drops, the instruction runs, and the running word is also 0xC000.
- R3: A host read of a null primitive (code 0) leaves the response word unchanged.
- R4: xfer_ready during a running instruction gives 0x8002 (come-again set, interrupts-allowed clear, code 2). This word is held for any number of cycles until it is read.
- R5: A read of 0x8002 changes the word to done, 0x0003. A read of 0x0003 changes the word to the idle null, 0x0000.
- R6: exc_raise latches an exception. Outside the busy wait of R2, a latched exception makes the word 0x0001 (code 1, both flags clear), taking precedence over the null, transfer and done primitives.
- R7: A pulse on ack_wr changes neither the response word nor the latched exception.
- R8: save_ctx clears the latched exception and ends any instruction, so the word becomes 0x0000. If exc_raise arrives in the same cycle, the new exception is kept.
- R9: A read of 0x0001 ends the current instruction but keeps the exception latched. With no save in between, the next instruction reports 0x0001 again once its unit is free.
- R10: instr_start is ignored while an instruction is in progress, for example in the transfer or done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_start | input | 1 | Host issued a new coprocessor instruction |
| unit_busy | input | 1 | Execution unit needed by the new instruction is still busy |
| xfer_ready | input | 1 | Output operand converted; transfer primitive can be offered |
| exc_raise | input | 1 | An execution unit signals an exception |
| ack_wr | input | 1 | Host write to the exception-acknowledge register |
| save_ctx | input | 1 | Context-save operation strobe |
| rsp_rd | input | 1 | Host read of the response register this cycle |
| rsp_word | output | RSP_W (16) | Current response word |

## Verification
Every input takes effect at the rising edge where it is sampled. The word for that input appears on rsp_word just after that edge, one cycle of latency, because all state and the word itself are registered. The bench therefore changes inputs 1 ns after a rising edge and compares rsp_word 1 ns after the following rising edge. Held-state requirements such as R4 and R2 are compared on every cycle of a long idle window, not only at its end.

// File: rtl/rsp_seq_pkg.sv
package rsp_seq_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RUN,
        PH_XFER,
        PH_DONE
    } phase_e;

    localparam logic [CODE_W-1:0] PRIM_NULL      = 4'd0;
    localparam logic [CODE_W-1:0] PRIM_TAKE_EXC  = 4'd1;
    localparam logic [CODE_W-1:0] PRIM_EVAL_XFER = 4'd2;
    localparam logic [CODE_W-1:0] PRIM_DONE      = 4'd3;

endpackage

// File: rtl/rsp_exc_latch.sv
module rsp_exc_latch (
    input  logic clk,
    input  logic rst,
    input  logic exc_raise,
    input  logic save_ctx,
    output logic pend_d,
    output logic pend_q
);

    typedef struct packed {
        logic pend;
    } latch_s;

    latch_s st_d, st_q;

    // Raise wins over a simultaneous save; acknowledge is deliberately absent.
    always_comb begin
        st_d      = st_q;
        st_d.pend = exc_raise | (st_q.pend & ~save_ctx);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_d = st_d.pend;
    assign pend_q = st_q.pend;

    p_raise_sets_r6: assert property (@(posedge clk) disable iff (rst)
        exc_raise |=> pend_q);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !save_ctx) |=> pend_q);

    p_save_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (save_ctx && !exc_raise) |=> !pend_q);

endmodule

// File: rtl/rsp_phase_fsm.sv
module rsp_phase_fsm
    import rsp_seq_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_start,
    input  logic          unit_busy,
    input  logic          xfer_ready,
    input  logic          save_ctx,
    input  logic          rsp_rd,
    input  logic [CW-1:0] rd_code,
    output phase_e        phase_d,
    output phase_e        phase_q
);

    typedef struct packed {
        phase_e phase;
    } fsm_s;

    fsm_s st_d, st_q;
    logic rd_take, rd_xfer, rd_done;

    always_comb begin
        rd_take = rsp_rd && (rd_code == CW'(PRIM_TAKE_EXC));
        rd_xfer = rsp_rd && (rd_code == CW'(PRIM_EVAL_XFER));
        rd_done = rsp_rd && (rd_code == CW'(PRIM_DONE));
        st_d    = st_q;
        if (save_ctx) begin
            st_d.phase = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (instr_start) st_d.phase = unit_busy ? PH_WAIT : PH_RUN;
                end
                PH_WAIT: begin
                    if (!unit_busy) st_d.phase = PH_RUN;
                end
                PH_RUN: begin
                    if (rd_take)         st_d.phase = PH_IDLE;
                    else if (xfer_ready) st_d.phase = PH_XFER;
                end
                PH_XFER: begin
                    if (rd_take)      st_d.phase = PH_IDLE;
                    else if (rd_xfer) st_d.phase = PH_DONE;
                end
                PH_DONE: begin
                    if (rd_take || rd_done) st_d.phase = PH_IDLE;
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_IDLE};
        else     st_q <= st_d;
    end

    assign phase_d = st_d.phase;
    assign phase_q = st_q.phase;

    p_xfer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_XFER && !rsp_rd && !save_ctx) |=> phase_q == PH_XFER);

    p_wait_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && unit_busy && !save_ctx) |=> phase_q == PH_WAIT);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !rsp_rd && !save_ctx) |=> phase_q == PH_DONE);

endmodule

// File: rtl/rsp_word_enc.sv
module rsp_word_enc
    import rsp_seq_pkg::*;
#(
    parameter int RSP_W = 16,
    parameter int CW    = CODE_W
) (
    input  phase_e           phase,
    input  logic             exc_pend,
    output logic [RSP_W-1:0] word
);

    localparam int CA_BIT = RSP_W - 1;
    localparam int IA_BIT = RSP_W - 2;

    generate
        if (RSP_W < CW + 2) begin : g_bad_width
            initial $error("rsp_word_enc: RSP_W too small for flags and code");
        end
    endgenerate

    logic          ca, ia;
    logic [CW-1:0] code;

    always_comb begin
        ca   = 1'b0;
        ia   = 1'b0;
        code = CW'(PRIM_NULL);
        if (phase == PH_WAIT) begin
            ca = 1'b1;
            ia = 1'b1;
        end else if (exc_pend) begin
            code = CW'(PRIM_TAKE_EXC);
        end else begin
            unique case (phase)
                PH_RUN:  begin ca = 1'b1; ia = 1'b1; end
                PH_XFER: begin ca = 1'b1; code = CW'(PRIM_EVAL_XFER); end
                PH_DONE: code = CW'(PRIM_DONE);
                default: code = CW'(PRIM_NULL);
            endcase
        end
        word         = '0;
        word[CA_BIT] = ca;
        word[IA_BIT] = ia;
        word[CW-1:0] = code;
    end

endmodule

// File: rtl/rsp_seq_top.sv
module rsp_seq_top
    import rsp_seq_pkg::*;
#(
    parameter int RSP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_start,
    input  logic             unit_busy,
    input  logic             xfer_ready,
    input  logic             exc_raise,
    input  logic             ack_wr,
    input  logic             save_ctx,
    input  logic             rsp_rd,
    output logic [RSP_W-1:0] rsp_word
);

    localparam int CW = CODE_W;

    typedef struct packed {
        logic [RSP_W-1:0] word;
    } top_s;

    top_s   st_d, st_q;
    phase_e phase_d, phase_q;
    logic   pend_d, pend_q;
    logic [RSP_W-1:0] enc_word;

    rsp_exc_latch u_exc (
        .clk       (clk),
        .rst       (rst),
        .exc_raise (exc_raise),
        .save_ctx  (save_ctx),
        .pend_d    (pend_d),
        .pend_q    (pend_q)
    );

    rsp_phase_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .instr_start (instr_start),
        .unit_busy   (unit_busy),
        .xfer_ready  (xfer_ready),
        .save_ctx    (save_ctx),
        .rsp_rd      (rsp_rd),
        .rd_code     (st_q.word[CW-1:0]),
        .phase_d     (phase_d),
        .phase_q     (phase_q)
    );

    rsp_word_enc #(.RSP_W(RSP_W), .CW(CW)) u_enc (
        .phase    (phase_d),
        .exc_pend (pend_d),
        .word     (enc_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.word = enc_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_word = st_q.word;

    p_exc_first_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && phase_q != PH_WAIT) |-> rsp_word[CW-1:0] == CW'(PRIM_TAKE_EXC));

    p_null_read_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_rd && rsp_word[CW-1:0] == CW'(PRIM_NULL) && phase_q != PH_IDLE
         && phase_q != PH_WAIT && !xfer_ready && !exc_raise && !save_ctx)
        |=> $stable(rsp_word));

    p_ack_no_effect_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && phase_q != PH_WAIT && !instr_start && !xfer_ready && !exc_raise
         && !save_ctx && !rsp_rd) |=> $stable(rsp_word));

endmodule

// File: tb/tb_rsp_seq_top.sv
module tb_rsp_seq_top;

    logic        clk = 1'b0;
    logic        rst, instr_start, unit_busy, xfer_ready, exc_raise, ack_wr, save_ctx, rsp_rd;
    logic [15:0] rsp_word;
    int          checks = 0;
    int          errors = 0;
    int          cyc    = 0;

    always #5 clk = ~clk;

    rsp_seq_top dut (
        .clk(clk), .rst(rst), .instr_start(instr_start), .unit_busy(unit_busy),
        .xfer_ready(xfer_ready), .exc_raise(exc_raise), .ack_wr(ack_wr),
        .save_ctx(save_ctx), .rsp_rd(rsp_rd), .rsp_word(rsp_word)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // States: 0 idle, 1 busy wait, 2 running, 3 transfer offered, 4 done
    function automatic logic [15:0] exp_word(int s, bit e);
        if (s == 1) return 16'hC000;
        if (e)      return 16'h0001;
        case (s)
            2:       return 16'hC000;
            3:       return 16'h8002;
            4:       return 16'h0003;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int after_read(int s, bit e);
        logic [15:0] w = exp_word(s, e);
        case (w[3:0])
            4'd1:    return 0;
            4'd2:    return 4;
            4'd3:    return 0;
            default: return s;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] exp);
        checks++;
        if (rsp_word !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, rsp_word, exp);
        end
    endtask

    task automatic step(bit st, bit xr, bit ex, bit ak, bit sv, bit rd);
        instr_start = st; xfer_ready = xr; exc_raise = ex;
        ack_wr = ak; save_ctx = sv; rsp_rd = rd;
        @(posedge clk); #1;
        instr_start = 0; xfer_ready = 0; exc_raise = 0;
        ack_wr = 0; save_ctx = 0; rsp_rd = 0;
    endtask

    task automatic do_reset();
        rst = 1; unit_busy = 0;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        rst = 0;
    endtask

    task automatic go_to(int s, bit e);
        do_reset();
        if (s == 1) begin unit_busy = 1; step(1, 0, 0, 0, 0, 0); end
        if (s >= 2) step(1, 0, 0, 0, 0, 0);
        if (s >= 3) step(0, 1, 0, 0, 0, 0);
        if (s == 4) step(0, 0, 0, 0, 0, 1);
        if (e) step(0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        rst = 1; instr_start = 0; unit_busy = 0; xfer_ready = 0; exc_raise = 0;
        ack_wr = 0; save_ctx = 0; rsp_rd = 0;
        @(posedge clk); #1;

        // R1: reset clears word and a pending exception
        go_to(2, 1);
        chk("R6", 16'h0001);
        do_reset();
        chk("R1", 16'h0000);
        step(1, 0, 0, 0, 0, 0);
        chk("R1", 16'hC000);

        // Sweep every state with and without a pending exception
        for (int s = 0; s < 5; s++) begin
            for (int e = 0; e < 2; e++) begin
                go_to(s, e[0]);
                chk((s == 1) ? "R2" : (e != 0) ? "R6" : "R4", exp_word(s, e[0]));
                step(0, 0, 0, 1, 0, 0);
                chk("R7", exp_word(s, e[0]));
                for (int k = 0; k < 20; k++) begin
                    step(0, 0, 0, 0, 0, 0);
                    chk((s == 3) ? "R4" : "R2", exp_word(s, e[0]));
                end
                step(1, 0, 0, 0, 0, 0);
                if (s != 0) chk("R10", exp_word(s, e[0]));

                go_to(s, e[0]);
                step(0, 0, 0, 0, 0, 1);
                chk((exp_word(s, e[0]) == 16'h0001) ? "R9" :
                    (exp_word(s, e[0]) == 16'h8002 || exp_word(s, e[0]) == 16'h0003) ? "R5" : "R3",
                    exp_word(after_read(s, e[0]), e[0]));

                go_to(s, e[0]);
                unit_busy = 0;
                step(0, 0, 0, 0, 1, 0);
                chk("R8", 16'h0000);
                step(1, 0, 0, 0, 0, 0);
                chk("R8", 16'hC000);
            end
        end

        // R5 full transfer sequence
        go_to(3, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R5", 16'h0003);
        step(0, 0, 0, 0, 0, 1);
        chk("R5", 16'h0000);

        // R2 exception during busy wait stays hidden until unit frees
        go_to(1, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R2", 16'hC000);
        unit_busy = 0;
        step(0, 0, 0, 0, 0, 0);
        chk("R6", 16'h0001);

        // R9 handler without save: exception taken again
        go_to(2, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R6", 16'h0001);
        step(0, 0, 0, 0, 0, 1);
        chk("R9", 16'h0001);
        step(0, 0, 0, 1, 0, 0);
        chk("R7", 16'h0001);
        unit_busy = 1;
        step(1, 0, 0, 0, 0, 0);
        chk("R9", 16'hC000);
        unit_busy = 0;
        step(0, 0, 0, 0, 0, 0);
        chk("R9", 16'h0001);
        step(0, 0, 0, 0, 1, 0);
        chk("R8", 16'h0000);
        step(1, 0, 0, 0, 0, 0);
        chk("R8", 16'hC000);

        // R8 save and raise together: raise kept
        go_to(2, 1);
        step(0, 0, 1, 0, 1, 0);
        chk("R8", 16'h0001);

        // R6 exception raised in transfer state preempts transfer
        go_to(3, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R6", 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule